// File: doc/BRIEF.md
# Wide-Row Access Buffer with Width Adaptation

This block is the front stage of a channel controller for a stacked DRAM with a very wide data bus. It sits between a narrow request port on the processor side and a wide command and data queue that leads toward the DRAM. It keeps one wide data chunk, the one fetched by the most recent DRAM command, in registers in the front-end clock domain. Narrow reads and writes that fall inside that chunk complete locally, and the DRAM channel stays idle.

A narrow access outside the held chunk is a miss. If the held chunk carries modified bytes, the block first sends a masked wide write with only those bytes enabled. It then sends a wide read for the new chunk and waits for the fill data. A pending narrow read is answered from the fill. A pending narrow write is merged into the fetched chunk. Narrow writes that hit are merged byte by byte into the held chunk and marked dirty, so several narrow writes go to DRAM as one wide transfer.

The narrow address counts narrow words. Its low bits pick a lane inside the wide chunk, and the bits above them form the chunk address.

Top module: `rowbuf_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, `rsp_valid` is 0, and no chunk is held, so the first access is a miss.
- R2: The lane is `req_addr[1:0]`, and lane k occupies bits [32k+31:32k] of the wide word. The chunk tag is `req_addr[15:2]`. An access hits when a chunk is held and its tag equals the request tag.
- R3: A read hit raises `rsp_valid` for one cycle, in the cycle after the request is accepted, with the selected lane. It issues no downstream command.
- R4: On a write hit, byte i of the narrow word (bits [8i+7:8i]) replaces the held byte when `req_be[i]` is 1 and leaves it unchanged otherwise. No command is issued, and `req_ready` stays 1.
- R5: A miss while no byte is dirty issues exactly one command: `cmd_write`=0, `cmd_addr` equal to the new tag, and `cmd_mask` all ones.
- R6: A miss while bytes are dirty first issues a write command with `cmd_addr` equal to the old tag, `cmd_wdata` equal to the held chunk, and `cmd_mask` bit 4k+i set exactly for dirty byte i of lane k. The read command for the new chunk follows.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command is held, and its valid, address, write flag, mask and data do not change.
- R8: Fill data is taken in the cycle `fill_valid` is 1 while waiting. A read miss answers with `rsp_valid` in the next cycle. A write miss merges its bytes into the fetched chunk, and only those bytes become dirty.
- R9: From acceptance of a miss until the cycle after the fill is taken, `req_ready` is 0.
- R10: A writeback clears all dirty bytes. A later miss with no new writes issues only a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Narrow request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Narrow-word address |
| req_wdata | input | 32 | Narrow write data |
| req_be | input | 4 | Byte enables for narrow write |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | Wide command present |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_write | output | 1 | 1 = masked wide write, 0 = wide read |
| cmd_addr | output | 14 | Wide chunk address |
| cmd_wdata | output | 128 | Wide write data |
| cmd_mask | output | 16 | Byte mask for wide write |
| fill_valid | input | 1 | Wide read data returning |
| fill_data | input | 128 | Wide read data |

## Verification
A read hit is due at the first falling edge after the accepting rising edge. A write hit shows `req_ready` still high at that same point. The bench samples on falling edges, so every comparison sees values settled after one registered step. For a miss, the bench's downstream model notes the cycle in which it drives `fill_valid`. It then requires the read response, or the return of `req_ready` for a write, exactly one cycle later, and it checks that `req_ready` stays low at every sample in between. The bench logs the commands it accepts and compares them, after each access, with the writeback and fetch sequence that a flat memory model and the tracked dirty bytes predict. It also checks on every cycle of backpressure that a held command has not changed.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FETCH,
        ST_WAIT
    } rb_state_e;
endpackage

// File: rtl/rowbuf_tag_cmp.sv
module rowbuf_tag_cmp #(
    parameter int TAG_W = 14
) (
    input  logic             held_vld,
    input  logic [TAG_W-1:0] held_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    assign hit = held_vld && (held_tag == probe_tag);
endmodule

// File: rtl/rowbuf_lane_merge.sv
module rowbuf_lane_merge #(
    parameter  int NARROW_W = 32,
    parameter  int WIDE_W   = 128,
    localparam int LANES    = WIDE_W / NARROW_W,
    localparam int LANE_W   = $clog2(LANES),
    localparam int NBYTES   = NARROW_W / 8,
    localparam int WBYTES   = WIDE_W / 8
) (
    input  logic [WIDE_W-1:0]   base,
    input  logic [LANE_W-1:0]   lane,
    input  logic [NBYTES-1:0]   be,
    input  logic [NARROW_W-1:0] wdata,
    output logic [WIDE_W-1:0]   merged,
    output logic [WBYTES-1:0]   touched
);
    for (genvar j = 0; j < WBYTES; j++) begin : g_byte
        localparam int LN = j / NBYTES;
        localparam int BI = j % NBYTES;
        assign touched[j] = (lane == LANE_W'(LN)) && be[BI];
        assign merged[8*j +: 8] = touched[j] ? wdata[8*BI +: 8] : base[8*j +: 8];
    end
endmodule

// File: rtl/rowbuf_lane_sel.sv
module rowbuf_lane_sel #(
    parameter  int NARROW_W = 32,
    parameter  int WIDE_W   = 128,
    localparam int LANES    = WIDE_W / NARROW_W,
    localparam int LANE_W   = $clog2(LANES)
) (
    input  logic [WIDE_W-1:0]   src,
    input  logic [LANE_W-1:0]   lane,
    output logic [NARROW_W-1:0] word
);
    logic [NARROW_W-1:0] lane_words [LANES];
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_words[k] = src[NARROW_W*k +: NARROW_W];
    end
    assign word = lane_words[lane];
endmodule

// File: rtl/rowbuf_cache.sv
module rowbuf_cache
    import rowbuf_pkg::*;
#(
    parameter  int ADDR_W   = 16,
    parameter  int NARROW_W = 32,
    parameter  int WIDE_W   = 128,
    localparam int LANES    = WIDE_W / NARROW_W,
    localparam int OFF_W    = $clog2(LANES),
    localparam int TAG_W    = ADDR_W - OFF_W,
    localparam int NBYTES   = NARROW_W / 8,
    localparam int WBYTES   = WIDE_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [NARROW_W-1:0] req_wdata,
    input  logic [NBYTES-1:0]   req_be,
    output logic                rsp_valid,
    output logic [NARROW_W-1:0] rsp_rdata,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic                cmd_write,
    output logic [TAG_W-1:0]    cmd_addr,
    output logic [WIDE_W-1:0]   cmd_wdata,
    output logic [WBYTES-1:0]   cmd_mask,
    input  logic                fill_valid,
    input  logic [WIDE_W-1:0]   fill_data
);
    typedef struct packed {
        rb_state_e           st;
        logic                vld;
        logic [TAG_W-1:0]    tag;
        logic [WIDE_W-1:0]   data;
        logic [WBYTES-1:0]   dirty;
        logic                p_wr;
        logic [ADDR_W-1:0]   p_addr;
        logic [NARROW_W-1:0] p_wdata;
        logic [NBYTES-1:0]   p_be;
        logic                rsp_v;
        logic [NARROW_W-1:0] rsp_d;
    } rb_regs_t;

    rb_regs_t q, d;

    logic                hit;
    logic                in_wait;
    logic [WIDE_W-1:0]   m_base;
    logic [OFF_W-1:0]    m_lane;
    logic [NBYTES-1:0]   m_be;
    logic [NARROW_W-1:0] m_wdata;
    logic [WIDE_W-1:0]   m_merged;
    logic [WBYTES-1:0]   m_touched;
    logic [NARROW_W-1:0] sel_word;

    assign in_wait = (q.st == ST_WAIT);
    assign m_base  = in_wait ? fill_data : q.data;
    assign m_lane  = in_wait ? q.p_addr[OFF_W-1:0] : req_addr[OFF_W-1:0];
    assign m_be    = in_wait ? q.p_be : req_be;
    assign m_wdata = in_wait ? q.p_wdata : req_wdata;

    rowbuf_tag_cmp #(.TAG_W(TAG_W)) u_tag (
        .held_vld (q.vld),
        .held_tag (q.tag),
        .probe_tag(req_addr[ADDR_W-1:OFF_W]),
        .hit      (hit)
    );

    rowbuf_lane_merge #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_merge (
        .base   (m_base),
        .lane   (m_lane),
        .be     (m_be),
        .wdata  (m_wdata),
        .merged (m_merged),
        .touched(m_touched)
    );

    rowbuf_lane_sel #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sel (
        .src (m_base),
        .lane(m_lane),
        .word(sel_word)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        if (req_write) begin
                            d.data  = m_merged;
                            d.dirty = q.dirty | m_touched;
                        end else begin
                            d.rsp_v = 1'b1;
                            d.rsp_d = sel_word;
                        end
                    end else begin
                        d.p_wr    = req_write;
                        d.p_addr  = req_addr;
                        d.p_wdata = req_wdata;
                        d.p_be    = req_be;
                        d.st      = (|q.dirty) ? ST_WBACK : ST_FETCH;
                    end
                end
            end
            ST_WBACK: begin
                if (cmd_ready) begin
                    d.dirty = '0;
                    d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (cmd_ready) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fill_valid) begin
                    d.vld = 1'b1;
                    d.tag = q.p_addr[ADDR_W-1:OFF_W];
                    d.st  = ST_IDLE;
                    if (q.p_wr) begin
                        d.data  = m_merged;
                        d.dirty = m_touched;
                    end else begin
                        d.data  = fill_data;
                        d.dirty = '0;
                        d.rsp_v = 1'b1;
                        d.rsp_d = sel_word;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
    assign cmd_valid = (q.st == ST_WBACK) || (q.st == ST_FETCH);
    assign cmd_write = (q.st == ST_WBACK);
    assign cmd_addr  = (q.st == ST_WBACK) ? q.tag : q.p_addr[ADDR_W-1:OFF_W];
    assign cmd_wdata = q.data;
    assign cmd_mask  = (q.st == ST_WBACK) ? q.dirty : '1;

    // R7: a command waiting on backpressure keeps its content
    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
            && $stable(cmd_write) && $stable(cmd_mask) && $stable(cmd_wdata));

    // R9: no request is taken while a downstream command is pending
    a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    // R6: a writeback always carries at least one enabled byte
    a_r6_wb_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_write |-> cmd_mask != '0);

    // R6: an accepted writeback is followed by the fetch
    a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_write && cmd_ready |=> cmd_valid && !cmd_write);

    // R5: a fetch requests the whole chunk
    a_r5_fetch_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |-> &cmd_mask);

    // R3 / R8: a response follows a read acceptance or a fill
    a_r3_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(fill_valid) || $past(req_valid && req_ready && !req_write));
endmodule

// File: tb/rowbuf_cache_test.sv
module rowbuf_cache_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         cmd_valid;
    logic         cmd_ready;
    logic         cmd_write;
    logic [13:0]  cmd_addr;
    logic [127:0] cmd_wdata;
    logic [15:0]  cmd_mask;
    logic         fill_valid;
    logic [127:0] fill_data;

    rowbuf_cache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit           w;
        int           addr;
        logic [127:0] data;
        logic [15:0]  mask;
    } cmd_t;

    int           n_chk = 0;
    int           n_fail = 0;
    int           cyc = 0;
    int           fill_cyc = -10;
    bit           bp = 1'b0;
    bit           finished = 1'b0;
    cmd_t         log_q[$];
    logic [31:0]  gold[int];
    logic [127:0] dram[int];
    bit           mvalid = 1'b0;
    int           mtag = 0;
    logic [15:0]  mdirty = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] init_w(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h13572468;
    endfunction

    function automatic logic [31:0] gold_w(int a);
        return gold.exists(a) ? gold[a] : init_w(a);
    endfunction

    function automatic logic [127:0] dram_w(int w);
        logic [127:0] r;
        if (dram.exists(w)) return dram[w];
        for (int k = 0; k < 4; k++) r[32*k +: 32] = init_w(w*4 + k);
        return r;
    endfunction

    // downstream model: flat wide memory with backpressure and fixed fill latency
    initial begin
        int           fcnt = 0;
        int           faddr = 0;
        int           rcnt = 0;
        bit           pv = 1'b0;
        bit           pr = 1'b0;
        bit           pw = 1'b0;
        logic [13:0]  pa = '0;
        logic [15:0]  pm = '0;
        logic [127:0] pd = '0;
        logic [127:0] tmp;
        cmd_ready  = 1'b0;
        fill_valid = 1'b0;
        fill_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                fill_valid = 1'b0;
                if (pv && !pr)
                    chk(cmd_valid && cmd_addr == pa && cmd_write == pw && cmd_mask == pm
                        && cmd_wdata == pd, "R7 command held under backpressure",
                        {cmd_write, cmd_mask, cmd_addr}, {pw, pm, pa});
                rcnt++;
                cmd_ready = bp ? (rcnt % 3 == 2) : 1'b1;
                if (cmd_valid && cmd_ready) begin
                    log_q.push_back('{cmd_write, int'(cmd_addr), cmd_wdata, cmd_mask});
                    if (cmd_write) begin
                        tmp = dram_w(int'(cmd_addr));
                        for (int j = 0; j < 16; j++)
                            if (cmd_mask[j]) tmp[8*j +: 8] = cmd_wdata[8*j +: 8];
                        dram[int'(cmd_addr)] = tmp;
                    end else begin
                        fcnt  = 3;
                        faddr = int'(cmd_addr);
                    end
                end else if (fcnt > 0) begin
                    fcnt--;
                    if (fcnt == 0) begin
                        fill_valid = 1'b1;
                        fill_data  = dram_w(faddr);
                        fill_cyc   = cyc;
                    end
                end
                pv = cmd_valid; pr = cmd_ready; pw = cmd_write;
                pa = cmd_addr;  pm = cmd_mask;  pd = cmd_wdata;
            end
        end
    end

    task automatic access(input bit wr, input int a, input logic [31:0] dat, input logic [3:0] be);
        int          t = a >> 2;
        int          ln = a & 3;
        bit          hit_e = mvalid && (t == mtag);
        bit          busy_ok = 1'b1;
        int          n = 0;
        logic [31:0] exp_rd = gold_w(a);
        logic [31:0] g;
        cmd_t        exp_q[$];
        string       lbl;
        if (!hit_e) begin
            if (mdirty != 0) exp_q.push_back('{1'b1, mtag, '0, mdirty});
            exp_q.push_back('{1'b0, t, '0, 16'hFFFF});
        end
        log_q.delete();
        req_write = wr; req_addr = a[15:0]; req_wdata = dat; req_be = be; req_valid = 1'b1;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 1'b0;
        if (hit_e) begin
            if (!wr) chk(rsp_valid && rsp_rdata == exp_rd, "R3 read hit data next cycle (R2 lane)",
                         {rsp_valid, rsp_rdata}, {1'b1, exp_rd});
            else chk(req_ready && !rsp_valid, "R4 write hit keeps req_ready",
                     {req_ready, rsp_valid}, 2'b10);
        end else begin
            n = 0;
            while (!(wr ? req_ready : rsp_valid) && n < 200) begin
                if (req_ready) busy_ok = 1'b0;
                @(negedge clk);
                n++;
            end
            chk(busy_ok && n < 200, "R9 req_ready low during miss", n, 0);
            chk(cyc == fill_cyc + 1, "R8 completion one cycle after fill", cyc, fill_cyc + 1);
            if (!wr) chk(rsp_rdata == exp_rd, "R8 read miss data", rsp_rdata, exp_rd);
        end
        if (hit_e) lbl = "R3 R4 no command on hit";
        else if (mdirty != 0) lbl = "R6 writeback then fetch";
        else lbl = "R5 R10 clean miss issues only a fetch";
        chk(log_q.size() == exp_q.size(), lbl, log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
            chk(log_q[i].w == exp_q[i].w && log_q[i].addr == exp_q[i].addr
                && log_q[i].mask == exp_q[i].mask, lbl,
                {log_q[i].w, log_q[i].mask, 32'(log_q[i].addr)},
                {exp_q[i].w, exp_q[i].mask, 32'(exp_q[i].addr)});
            if (log_q[i].w)
                for (int j = 0; j < 16; j++)
                    if (log_q[i].mask[j]) begin
                        g = gold_w(mtag*4 + j/4);
                        chk(log_q[i].data[8*j +: 8] == g[8*(j%4) +: 8], "R6 writeback byte data",
                            log_q[i].data[8*j +: 8], g[8*(j%4) +: 8]);
                    end
        end
        if (!hit_e) begin
            mvalid = 1'b1; mtag = t; mdirty = '0;
        end
        if (wr) begin
            g = gold_w(a);
            for (int i = 0; i < 4; i++) if (be[i]) g[8*i +: 8] = dat[8*i +: 8];
            gold[a] = g;
            mdirty = mdirty | (16'(be) << (4*ln));
        end
    endtask

    initial begin
        int cnt = 0;
        wait (cyc >= 100000 || finished);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !rsp_valid, "R1 reset state",
            {req_ready, cmd_valid, rsp_valid}, 3'b100);
        access(1'b0, 'h10, '0, 4'h0);                  // R1 first access misses, R5
        access(1'b0, 'h11, '0, 4'h0);                  // R3 hit, lane 1 (R2)
        access(1'b1, 'h12, 32'hDEADBEEF, 4'b0101);     // R4 partial write hit
        access(1'b0, 'h12, '0, 4'h0);                  // R4 merged bytes read back
        access(1'b1, 'h13, 32'h01234567, 4'b1111);
        bp = 1'b1;                                     // R7 backpressure
        access(1'b0, 'h20, '0, 4'h0);                  // R6 mask 16'hF500 then fetch
        access(1'b0, 'h21, '0, 4'h0);
        access(1'b1, 'h31, 32'hCAFEF00D, 4'b1111);     // R8 write miss merged
        access(1'b0, 'h31, '0, 4'h0);
        access(1'b0, 'h30, '0, 4'h0);
        access(1'b0, 'h10, '0, 4'h0);                  // R6 writeback of lane 1
        access(1'b0, 'h12, '0, 4'h0);                  // R6 data reached memory
        access(1'b0, 'h20, '0, 4'h0);                  // R10 only a fetch
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < 16; k++)
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            bp = lf[15];
            access(lf[6], int'(lf[5:0]), {lf, lf ^ 16'hBEEF},
                   (lf[11:8] == 4'h0) ? 4'h1 : lf[11:8]);
        end
        repeat (5) @(negedge clk);
        chk(!cmd_valid && !rsp_valid && req_ready, "R3 quiet when idle",
            {cmd_valid, rsp_valid, req_ready}, 3'b001);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule